// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of week, date, month and two-digit year. A prescaler divides the fast input clock down to one advance per second. Every advance steps the seconds. A carry ripples through minutes and hours, and at midnight it also steps the day of week, the date, the month and the year. Month length and leap years decide where the date wraps.

Software sets the clock through a one-cycle load port that writes a single field. The reserved bits of each field are dropped as the write lands. The seconds byte also carries a halt flag that stops all counting. Any write to the seconds field restarts the sub-second prescaler, so a full second passes before the first advance. The hours byte carries its own format flag, which selects 12-hour counting with an AM/PM flag or 24-hour counting. All seven bytes are visible on the outputs at all times.

Top module: `rtc_calendar`

## Requirements
- R1: After synchronous active-low reset the outputs read seconds 0x00 with the halt flag clear, minutes 0x00, hours 0x00 in 24-hour format, day 0x01, date 0x01, month 0x01 and year 0x00.
- R2: A cycle with wr_en high writes wr_data into the field chosen by wr_sel: 0 seconds, 1 minutes, 2 hours, 3 day, 4 date, 5 month, 6 year. Code 7 changes nothing. Reserved bits always read 0: minutes bit 7, hours bit 7, day bits 7..3, date bits 7..6 and month bits 7..5.
- R3: While running, seconds (bits 6..0 of the seconds byte) advance in BCD once every TICK_HZ clock cycles, and 59 wraps to 00 with a carry into minutes.
- R4: Minutes advance in BCD on that carry, and 59 wraps to 00 with a carry into hours.
- R5: With hours bit 6 at 0 (24-hour format), hours bits 5..0 count 00 to 23 in BCD, and the step from 23 to 00 is midnight.
- R6: With hours bit 6 at 1 (12-hour format), bits 4..0 count 1 to 12 in BCD and bit 5 is the PM flag (1 = PM). The step from 11 goes to 12 and toggles PM, and the step from 12 goes to 01. The step from 11 PM to 12 AM is midnight.
- R7: The day of week (01 to 07) advances at each midnight and wraps from 07 to 01. It does not change at any other advance.
- R8: At midnight the date advances and wraps to 01 after the month's last date, which is 30 for months 04, 06, 09 and 11, 28 or 29 for month 02, and 31 otherwise. The wrap advances the month, 12 wraps to 01 and advances the year, and the year wraps from 99 to 00.
- R9: February ends on 29 when the year value is divisible by 4, including 00, and on 28 otherwise.
- R10: While seconds bit 7 (halt) is 1, no field advances and the prescaler holds its count.
- R11: A write to the seconds field restarts the prescaler, so the first advance after it comes exactly TICK_HZ cycles after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock driving the prescaler |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle field write strobe |
| wr_sel | input | 3 | Field chosen for the write |
| wr_data | input | 8 | Byte to write |
| sec_q | output | 8 | Halt flag (bit 7) and BCD seconds |
| min_q | output | 8 | BCD minutes |
| hour_q | output | 8 | Format flag, PM or tens-of-twenty bit, and BCD hours |
| day_q | output | 8 | Day of week 1 to 7 |
| date_q | output | 8 | BCD date of month |
| month_q | output | 8 | BCD month |
| year_q | output | 8 | BCD year |

## Verification
The range properties assume that every loaded byte is a legal BCD value for its field and that any loaded date exists in its month. A loaded date of 0x31 in month 04, for example, would leave the date stuck beyond its wrap point. The sequencing properties assume that a write can be the only cause of a change other than the once-per-second carry chain. The stimulus builds every load from a binary reference state converted to BCD, with each value drawn inside its legal range. It sets the reserved bits only on top of legal low-order values, and it writes code 7 only while the clock is halted.

// File: rtl/rtc_pkg.sv
// Shared field codes, write masks and BCD helpers for the calendar clock.
// Assumes every BCD operand handed to these helpers is a legal digit pair.
package rtc_pkg;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DAY   = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_NONE  = 3'd7
    } fld_e;

    localparam logic [7:0] MASK_SEC   = 8'hFF;
    localparam logic [7:0] MASK_MIN   = 8'h7F;
    localparam logic [7:0] MASK_HOUR  = 8'h7F;
    localparam logic [7:0] MASK_DAY   = 8'h07;
    localparam logic [7:0] MASK_DATE  = 8'h3F;
    localparam logic [7:0] MASK_MONTH = 8'h1F;
    localparam logic [7:0] MASK_YEAR  = 8'hFF;

    // Add one to a two-digit BCD byte (no wrap handling beyond the digit carry).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap test on the low five bits of a BCD year: value divisible by four.
    function automatic logic leap_bcd(input logic [4:0] y);
        case (y[3:0])
            4'd0, 4'd4, 4'd8: return ~y[4];
            4'd2, 4'd6:       return y[4];
            default:          return 1'b0;
        endcase
    endfunction

    // Last date of a BCD month.
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the fast clock to a one-cycle tick every TICK_HZ cycles.
// Assumes TICK_HZ >= 2. The count holds while run is low and clears on restart.
module rtc_prescaler #(
    parameter int TICK_HZ = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = $clog2(TICK_HZ);
    localparam logic [CW-1:0] LAST = CW'(TICK_HZ - 1);

    logic [CW-1:0] cnt;

    // Tick on the last count of a running, non-restarted period.
    assign tick = run && !restart && (cnt == LAST);

    // Sub-second counter: clear on restart, freeze while halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_time_chain.sv
// Seconds, minutes and hours registers with BCD carries and 12/24-hour rules.
// Assumes loaded values are legal for their field. A write to a field wins
// over an advance in the same cycle and blocks the carry past that field.
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_q,
    output logic [7:0] min_q,
    output logic [7:0] hour_q,
    output logic       midnight
);
    logic wr_sec, wr_min, wr_hour;
    logic sec_wrap, min_adv, min_wrap, hour_adv;
    logic [7:0] sec_nx, min_nx, hour_nx, h12_inc;
    logic hour_mid;

    // Field write decode.
    assign wr_sec  = wr_en && (wr_sel == FLD_SEC);
    assign wr_min  = wr_en && (wr_sel == FLD_MIN);
    assign wr_hour = wr_en && (wr_sel == FLD_HOUR);

    // Carry chain across the three time fields.
    assign sec_wrap = tick && (sec_q[6:0] == 7'h59);
    assign min_adv  = sec_wrap;
    assign min_wrap = min_adv && !wr_min && (min_q[6:0] == 7'h59);
    assign hour_adv = min_wrap;
    assign midnight = hour_adv && !wr_hour && hour_mid;

    // Next seconds and minutes values.
    always_comb begin
        sec_nx = (sec_q[6:0] == 7'h59) ? {sec_q[7], 7'h00} : {sec_q[7], bcd_inc({1'b0, sec_q[6:0]}) & 8'h7F};
        min_nx = (min_q[6:0] == 7'h59) ? 8'h00 : bcd_inc(min_q);
    end

    // Next hour value and midnight detection in either format.
    always_comb begin
        h12_inc  = bcd_inc({3'b000, hour_q[4:0]});
        hour_nx  = hour_q;
        hour_mid = 1'b0;
        if (hour_q[6]) begin
            if (hour_q[4:0] == 5'h11) begin
                hour_nx  = {2'b01, ~hour_q[5], 5'h12};
                hour_mid = hour_q[5];
            end else if (hour_q[4:0] == 5'h12) begin
                hour_nx = {2'b01, hour_q[5], 5'h01};
            end else begin
                hour_nx = {2'b01, hour_q[5], h12_inc[4:0]};
            end
        end else begin
            if (hour_q[5:0] == 6'h23) begin
                hour_nx  = 8'h00;
                hour_mid = 1'b1;
            end else begin
                hour_nx = bcd_inc(hour_q);
            end
        end
    end

    // Seconds register, halt flag included.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= 8'h00;
        end else if (wr_sec) begin
            sec_q <= wr_data & MASK_SEC;
        end else if (tick) begin
            sec_q <= sec_nx;
        end
    end

    // Minutes register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= 8'h00;
        end else if (wr_min) begin
            min_q <= wr_data & MASK_MIN;
        end else if (min_adv) begin
            min_q <= min_nx;
        end
    end

    // Hours register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hour_q <= 8'h00;
        end else if (wr_hour) begin
            hour_q <= wr_data & MASK_HOUR;
        end else if (hour_adv) begin
            hour_q <= hour_nx;
        end
    end
endmodule

// File: rtl/rtc_date_chain.sv
// Day-of-week, date, month and year registers advanced by the midnight pulse.
// Assumes a loaded date exists in its month. A write wins over an advance
// and blocks the carry past the written field.
module rtc_date_chain
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       midnight,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] day_q,
    output logic [7:0] date_q,
    output logic [7:0] month_q,
    output logic [7:0] year_q
);
    logic wr_day, wr_date, wr_month, wr_year;
    logic is_leap, date_wrap, month_adv, month_wrap, year_adv;
    logic [7:0] last_date;

    // Field write decode.
    assign wr_day   = wr_en && (wr_sel == FLD_DAY);
    assign wr_date  = wr_en && (wr_sel == FLD_DATE);
    assign wr_month = wr_en && (wr_sel == FLD_MONTH);
    assign wr_year  = wr_en && (wr_sel == FLD_YEAR);

    // Month length from the month value and the leap test.
    assign is_leap   = leap_bcd(year_q[4:0]);
    assign last_date = month_last(month_q, is_leap);

    // Carry chain across the date fields.
    assign date_wrap  = midnight && (date_q == last_date);
    assign month_adv  = date_wrap && !wr_date;
    assign month_wrap = month_adv && !wr_month && (month_q == 8'h12);
    assign year_adv   = month_wrap;

    // Day-of-week register, 1 to 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            day_q <= 8'h01;
        end else if (wr_day) begin
            day_q <= wr_data & MASK_DAY;
        end else if (midnight) begin
            day_q <= (day_q == 8'h07) ? 8'h01 : day_q + 8'h01;
        end
    end

    // Date register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            date_q <= 8'h01;
        end else if (wr_date) begin
            date_q <= wr_data & MASK_DATE;
        end else if (midnight) begin
            date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
        end
    end

    // Month register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            month_q <= 8'h01;
        end else if (wr_month) begin
            month_q <= wr_data & MASK_MONTH;
        end else if (month_adv) begin
            month_q <= (month_q == 8'h12) ? 8'h01 : bcd_inc(month_q);
        end
    end

    // Year register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            year_q <= 8'h00;
        end else if (wr_year) begin
            year_q <= wr_data & MASK_YEAR;
        end else if (year_adv) begin
            year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
// Top of the BCD calendar clock: prescaler, time chain and date chain.
// Assumes the caller loads only legal BCD values. The halt flag lives in
// seconds bit 7, and any seconds write restarts the prescaler.
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int TICK_HZ = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_q,
    output logic [7:0] min_q,
    output logic [7:0] hour_q,
    output logic [7:0] day_q,
    output logic [7:0] date_q,
    output logic [7:0] month_q,
    output logic [7:0] year_q
);
    logic restart, run, tick, midnight;

    // Seconds writes restart the divider, and the halt flag stops it.
    assign restart = wr_en && (wr_sel == FLD_SEC);
    assign run     = !sec_q[7];

    rtc_prescaler #(.TICK_HZ(TICK_HZ)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (tick)
    );

    rtc_time_chain u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .sec_q    (sec_q),
        .min_q    (min_q),
        .hour_q   (hour_q),
        .midnight (midnight)
    );

    rtc_date_chain u_date (
        .clk      (clk),
        .rst_n    (rst_n),
        .midnight (midnight),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .day_q    (day_q),
        .date_q   (date_q),
        .month_q  (month_q),
        .year_q   (year_q)
    );
endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for rtc_calendar, attached by bind.
// Assumes legal BCD loads, as stated in the brief.
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] sec_q,
    input logic [7:0] min_q,
    input logic [7:0] hour_q,
    input logic [7:0] day_q,
    input logic [7:0] date_q,
    input logic [7:0] month_q,
    input logic [7:0] year_q
);
    p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (min_q[7] == 1'b0) && (hour_q[7] == 1'b0) && (day_q[7:3] == 5'd0)
        && (date_q[7:6] == 2'd0) && (month_q[7:5] == 3'd0));

    p_sec_bcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[3:0] <= 4'd9) && (sec_q[6:4] <= 3'd5));

    p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(sec_q[6:0]) || (sec_q[6:0] == 7'h00)
                    || (sec_q[6:0] > $past(sec_q[6:0]))));

    p_hour24_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hour_q[6] |-> (hour_q[5:0] <= 6'h23) && (hour_q[3:0] <= 4'd9));

    p_hour12_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hour_q[6] |-> (hour_q[4:0] >= 5'h01) && (hour_q[4:0] <= 5'h12));

    p_day_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (day_q >= 8'h01) && (day_q <= 8'h07));

    p_day_with_hour_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(day_q) || !$stable(hour_q)));

    p_month_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (month_q >= 8'h01) && (month_q <= 8'h12));

    p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[7] && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)
                                  && $stable(day_q) && $stable(date_q)
                                  && $stable(month_q) && $stable(year_q)));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .sec_q   (sec_q),
    .min_q   (min_q),
    .hour_q  (hour_q),
    .day_q   (day_q),
    .date_q  (date_q),
    .month_q (month_q),
    .year_q  (year_q)
);

// File: tb/rtc_calendar_test.sv
// Self-checking bench for rtc_calendar: directed corners plus seeded random
// loads, compared against a binary reference model kept in the bench.
module rtc_calendar_test;
    localparam int DIV = 8;

    typedef struct {
        int s; int m; int h; int day; int date; int mon; int yr; bit m12;
    } tm_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_q, min_q, hour_q, day_q, date_q, month_q, year_q;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtc_calendar #(.TICK_HZ(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .day_q(day_q),
        .date_q(date_q), .month_q(month_q), .year_q(year_q)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int dim(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] enc_hour(input tm_t t);
        int h12;
        if (!t.m12) return bcd(t.h);
        h12 = (t.h % 12 == 0) ? 12 : t.h % 12;
        return 8'h40 | ((t.h >= 12) ? 8'h20 : 8'h00) | bcd(h12);
    endfunction

    function automatic logic [55:0] enc(input tm_t t);
        return {bcd(t.s), bcd(t.m), enc_hour(t), bcd(t.day), bcd(t.date), bcd(t.mon), bcd(t.yr)};
    endfunction

    function automatic tm_t adv(input tm_t t);
        t.s = t.s + 1;
        if (t.s == 60) begin
            t.s = 0; t.m = t.m + 1;
            if (t.m == 60) begin
                t.m = 0; t.h = t.h + 1;
                if (t.h == 24) begin
                    t.h = 0;
                    t.day = (t.day == 7) ? 1 : t.day + 1;
                    if (t.date == dim(t.mon, t.yr)) begin
                        t.date = 1;
                        if (t.mon == 12) begin
                            t.mon = 1; t.yr = (t.yr + 1) % 100;
                        end else begin
                            t.mon = t.mon + 1;
                        end
                    end else begin
                        t.date = t.date + 1;
                    end
                end
            end
        end
        return t;
    endfunction

    function automatic tm_t mk(input int s, m, h, day, date, mon, yr, input bit m12);
        tm_t t;
        t.s = s; t.m = m; t.h = h; t.day = day; t.date = date; t.mon = mon; t.yr = yr; t.m12 = m12;
        return t;
    endfunction

    function automatic logic [55:0] outs();
        return {sec_q, min_q, hour_q, day_q, date_q, month_q, year_q};
    endfunction

    task automatic chk(input logic [55:0] got, input logic [55:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive one write; called at a negedge, returns at the following negedge.
    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Load a full state, seconds first so the prescaler restarts.
    task automatic load(input tm_t t);
        logic [55:0] e;
        e = enc(t);
        wr(3'd0, e[55:48]); wr(3'd1, e[47:40]); wr(3'd2, e[39:32]);
        wr(3'd3, e[31:24]); wr(3'd4, e[23:16]); wr(3'd5, e[15:8]); wr(3'd6, e[7:0]);
    endtask

    // Load, run n seconds, compare against the reference model.
    task automatic run_case(input tm_t t, input int n, input string tag);
        tm_t e;
        load(t);
        repeat (DIV * n - 6) @(posedge clk);
        @(negedge clk);
        e = t;
        for (int i = 0; i < n; i++) e = adv(e);
        chk(outs(), enc(e), tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [55:0] snap;
        tm_t t;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs(), 56'h00_00_00_01_01_01_00, "R1 reset state");

        // Halt, then reserved bits are dropped on write (R2).
        wr(3'd0, 8'h80);
        wr(3'd1, 8'hC5); chk({56'(min_q)}, 56'h45, "R2 minutes reserved bit");
        wr(3'd2, 8'h92); chk({56'(hour_q)}, 56'h12, "R2 hours reserved bit");
        wr(3'd3, 8'hFB); chk({56'(day_q)}, 56'h03, "R2 day reserved bits");
        wr(3'd4, 8'hD7); chk({56'(date_q)}, 56'h17, "R2 date reserved bits");
        wr(3'd5, 8'hE9); chk({56'(month_q)}, 56'h09, "R2 month reserved bits");
        wr(3'd6, 8'h42); chk({56'(year_q)}, 56'h42, "R2 year write");
        snap = outs();
        wr(3'd7, 8'hFF);
        chk(outs(), snap, "R2 code 7 ignored");
        repeat (5 * DIV) @(posedge clk);
        @(negedge clk);
        chk(outs(), snap, "R10 halted fields frozen");

        // Clear halt: seconds write restarts the prescaler (R11).
        wr(3'd0, 8'h30);
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        chk({56'(sec_q)}, 56'h30, "R11 no advance before full period");
        @(posedge clk);
        @(negedge clk);
        chk({56'(sec_q)}, 56'h31, "R11 R10 advance one period after restart");

        // Directed rollovers.
        run_case(mk(58, 10, 7, 2, 14, 6, 21, 0), 2, "R3 seconds carry");
        run_case(mk(59, 59, 13, 3, 9, 8, 50, 0), 1, "R4 minutes carry");
        run_case(mk(59, 59, 23, 7, 31, 12, 99, 0), 1, "R5 R7 R8 24h midnight year wrap");
        run_case(mk(59, 59, 11, 4, 5, 3, 12, 1), 1, "R6 11AM to 12PM");
        run_case(mk(59, 59, 12, 4, 5, 3, 12, 1), 1, "R6 12PM to 1PM");
        run_case(mk(59, 59, 23, 7, 31, 12, 99, 1), 1, "R6 R7 11PM to 12AM midnight");
        run_case(mk(59, 59, 0, 1, 1, 1, 0, 1), 1, "R6 12AM to 1AM");
        run_case(mk(59, 59, 23, 5, 28, 2, 24, 0), 1, "R9 Feb 28 leap");
        run_case(mk(59, 59, 23, 6, 29, 2, 24, 0), 1, "R9 Feb 29 wraps");
        run_case(mk(59, 59, 23, 5, 28, 2, 23, 0), 1, "R9 Feb 28 common wraps");
        run_case(mk(59, 59, 23, 5, 28, 2, 0, 0), 1, "R9 year 00 leap");
        run_case(mk(59, 59, 23, 1, 30, 4, 33, 0), 1, "R8 30-day month wrap");
        run_case(mk(59, 59, 23, 1, 30, 5, 33, 0), 1, "R8 31-day month no wrap");

        // Seeded random loads biased toward carries.
        for (int k = 0; k < 30; k++) begin
            t.m12  = $urandom % 2;
            t.mon  = 1 + $urandom % 12;
            t.yr   = ($urandom % 4 == 0) ? 99 : $urandom % 100;
            t.date = dim(t.mon, t.yr) - ($urandom % 2);
            t.day  = 1 + $urandom % 7;
            t.h    = ($urandom % 2) ? 23 : $urandom % 24;
            t.m    = ($urandom % 2) ? 59 : $urandom % 60;
            t.s    = 50 + $urandom % 10;
            run_case(t, 1 + $urandom % 15, "R3/R4/R5/R6/R7/R8/R9 random");
        end

        finish_run();
    end
endmodule